// File: doc/BRIEF.md
# Trap Entry State Save Unit

This block performs the architectural bookkeeping a processor core carries out when it takes a trap. When a trap is requested, it captures the current trap level, global level, condition codes, address space identifier, processor-state word, hyper-state word, window pointer, free-window count, PC, NPC and trap type. It then writes one trap-stack entry and, in the following cycle, presents the updated state registers for the core to load.

The trap-stack entry is addressed by the incremented trap level. It holds a packed state word, the saved PC and NPC, the saved hyper-state word and the trap type. The updated state depends on the entry mode. The mode is privileged, hyperprivileged, or the reset/error (RED) entry, and each mode applies its own bit rules to the state words and its own ceiling on the global level. The window pointer rotates according to the range the trap type falls in.

The controller has three states. IDLE waits for a request; a request seen in IDLE captures the inputs and moves to SAVE (transition IDLE->SAVE). SAVE drives the trap-stack write for one cycle and always moves to COMMIT (SAVE->COMMIT). COMMIT presents the new state for one cycle and always returns to IDLE (COMMIT->IDLE). Without a request, IDLE stays in IDLE.

Top module: `trap_entry_unit`

## Requirements
- R1: A `trap_req` sampled high in IDLE raises `stk_we` for exactly the next cycle and `upd_valid` for exactly the cycle after that. `busy` is high in both of those cycles and low otherwise, and both strobes are low after reset.
- R2: `stk_tstate` carries the captured global level zero-extended in bits 42:40, the condition codes in 39:32, the address space identifier in 31:24, the 13-bit processor-state word in 20:8 and the window pointer zero-extended in 4:0. All other bits are zero.
- R3: During the write, `stk_tpc`, `stk_tnpc`, `stk_htstate` and `stk_tt` equal the captured PC, NPC, hyper-state word and trap type. `stk_idx` equals the captured trap level plus one, limited to MAX_TL.
- R4: `new_tl` is the captured trap level plus one, saturating at MAX_TL.
- R5: `new_gl` is the captured global level plus one. It saturates at MAX_PGL in privileged mode and at MAX_GL in hyperprivileged and RED modes.
- R6: In privileged and hyperprivileged modes, processor-state bit 4 is set and bits 3 and 1 are cleared.
- R7: Hyperprivileged mode (`to_hyp`=1, `red_entry`=0) behaves as follows. Processor-state bit 9 is cleared. In the hyper-state word, bits 5 and 10 are cleared and bit 2 is set. Hyper-state bit 0 and processor-state bit 2 are unchanged.
- R8: Privileged mode (`to_hyp`=0, `red_entry`=0) sets processor-state bit 2, copies processor-state bit 8 into bit 9, and leaves the hyper-state word unchanged.
- R9: RED mode (`red_entry`=1, which overrides `to_hyp`) builds the new processor-state word as bit 4 set, bit 2 kept, and all other bits zero. In the new hyper-state word, bits 5 and 2 are set, bits 10 and 0 are cleared, and the other bits are kept.
- R10: For trap types 0x080 to 0x0BF, `new_cwp` = (cwp + cansave + 2) mod NWIN.
- R11: For trap types 0x0C0 to 0x0FF, `new_cwp` = (cwp - 1) mod NWIN. For trap type 0x024, `new_cwp` = (cwp + 1) mod NWIN. For any other type the window pointer is unchanged.
- R12: A `trap_req` that arrives while `busy` is high is ignored. No further write occurs, and the outputs keep reflecting the trap already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_req | input | 1 | Trap strobe, accepted in IDLE |
| to_hyp | input | 1 | Enter hyperprivileged mode |
| red_entry | input | 1 | RED-state entry, overrides to_hyp |
| cur_tl | input | TL_W (3) | Current trap level |
| cur_gl | input | GL_W (2) | Current global level |
| cur_ccr | input | 8 | Condition codes |
| cur_asi | input | 8 | Address space identifier |
| cur_pstate | input | 13 | Processor-state word |
| cur_hpstate | input | 11 | Hyper-state word |
| cur_cwp | input | CWP_W (3) | Current window pointer |
| cur_cansave | input | CWP_W (3) | Free save-window count |
| cur_pc | input | PC_W (48) | Current PC |
| cur_npc | input | PC_W (48) | Current NPC |
| trap_type | input | 9 | Trap type |
| busy | output | 1 | Sequence in progress |
| stk_we | output | 1 | Trap-stack write strobe |
| stk_idx | output | TL_W (3) | Trap-stack entry index |
| stk_tstate | output | 43 | Packed saved state |
| stk_tpc | output | PC_W (48) | Saved PC |
| stk_tnpc | output | PC_W (48) | Saved NPC |
| stk_htstate | output | 11 | Saved hyper-state word |
| stk_tt | output | 9 | Saved trap type |
| upd_valid | output | 1 | New-state strobe |
| new_tl | output | TL_W (3) | New trap level |
| new_gl | output | GL_W (2) | New global level |
| new_pstate | output | 13 | New processor-state word |
| new_hpstate | output | 11 | New hyper-state word |
| new_cwp | output | CWP_W (3) | New window pointer |

## Verification
The assertions assume that `cur_gl` never exceeds MAX_GL and that `cur_tl` never exceeds MAX_TL, because the saturation checks bound the results by those limits. They also assume that the requesting core does not depend on a strobe issued while `busy` is high. The directed scenarios keep every level input within its ceiling. They exercise the ceilings only through inputs at or one below them, and they raise the strobe during a busy cycle only in the scenario that checks it is ignored.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

    localparam int PST_W    = 13;
    localparam int HPST_W   = 11;
    localparam int CCR_W    = 8;
    localparam int ASI_W    = 8;
    localparam int TT_W     = 9;
    localparam int TSTATE_W = 43;

    // processor-state bit positions
    localparam int PS_IE   = 1;
    localparam int PS_PRIV = 2;
    localparam int PS_AM   = 3;
    localparam int PS_PEF  = 4;
    localparam int PS_TLE  = 8;
    localparam int PS_CLE  = 9;

    // hyper-state bit positions
    localparam int HS_TLZ   = 0;
    localparam int HS_HPRIV = 2;
    localparam int HS_RED   = 5;
    localparam int HS_IBE   = 10;

    localparam logic [TT_W-1:0] TT_CLEAN_WIN = 9'h024;

    typedef enum logic [1:0] {ST_IDLE, ST_SAVE, ST_COMMIT} tes_state_e;
    typedef enum logic [1:0] {MODE_PRIV, MODE_HYP, MODE_RED} tes_mode_e;

endpackage

// File: rtl/trap_tstate_pack.sv
module trap_tstate_pack
    import trap_entry_pkg::*;
#(
    parameter int GL_W  = 2,
    parameter int CWP_W = 3
) (
    input  logic [GL_W-1:0]     gl_i,
    input  logic [CCR_W-1:0]    ccr_i,
    input  logic [ASI_W-1:0]    asi_i,
    input  logic [PST_W-1:0]    pstate_i,
    input  logic [CWP_W-1:0]    cwp_i,
    output logic [TSTATE_W-1:0] word_o
);
    always_comb begin
        word_o        = '0;
        word_o[42:40] = 3'(gl_i);
        word_o[39:32] = ccr_i;
        word_o[31:24] = asi_i;
        word_o[20:8]  = pstate_i;
        word_o[4:0]   = 5'(cwp_i);
    end
endmodule

// File: rtl/trap_cwp_rotate.sv
module trap_cwp_rotate
    import trap_entry_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int CWP_W = 3
) (
    input  logic [TT_W-1:0]  tt_i,
    input  logic [CWP_W-1:0] cwp_i,
    input  logic [CWP_W-1:0] cansave_i,
    output logic [CWP_W-1:0] cwp_o
);
    localparam int SUM_W = CWP_W + 2;

    logic [SUM_W-1:0] spill_sum, fill_sum, clean_sum;
    logic             is_spill, is_fill, is_clean;

    always_comb begin
        spill_sum = SUM_W'(cwp_i) + SUM_W'(cansave_i) + SUM_W'(2);
        fill_sum  = SUM_W'(cwp_i) + SUM_W'(NWIN - 1);
        clean_sum = SUM_W'(cwp_i) + SUM_W'(1);
        is_spill  = (tt_i[8:6] == 3'b010);
        is_fill   = (tt_i[8:6] == 3'b011);
        is_clean  = (tt_i == TT_CLEAN_WIN);
        if (is_spill)
            cwp_o = CWP_W'(spill_sum % SUM_W'(NWIN));
        else if (is_fill)
            cwp_o = CWP_W'(fill_sum % SUM_W'(NWIN));
        else if (is_clean)
            cwp_o = CWP_W'(clean_sum % SUM_W'(NWIN));
        else
            cwp_o = cwp_i;
    end
endmodule

// File: rtl/trap_state_xform.sv
module trap_state_xform
    import trap_entry_pkg::*;
#(
    parameter int GL_W    = 2,
    parameter int MAX_GL  = 3,
    parameter int MAX_PGL = 2
) (
    input  tes_mode_e         mode_i,
    input  logic [GL_W-1:0]   gl_i,
    input  logic [PST_W-1:0]  pstate_i,
    input  logic [HPST_W-1:0] hpstate_i,
    output logic [GL_W-1:0]   gl_o,
    output logic [PST_W-1:0]  pstate_o,
    output logic [HPST_W-1:0] hpstate_o
);
    logic [GL_W:0] gl_inc, gl_cap;

    always_comb begin
        gl_inc = (GL_W+1)'(gl_i) + (GL_W+1)'(1);
        gl_cap = (mode_i == MODE_PRIV) ? (GL_W+1)'(MAX_PGL) : (GL_W+1)'(MAX_GL);
        gl_o   = (gl_inc > gl_cap) ? GL_W'(gl_cap) : GL_W'(gl_inc);

        pstate_o  = pstate_i;
        hpstate_o = hpstate_i;
        unique case (mode_i)
            MODE_RED: begin
                pstate_o            = '0;
                pstate_o[PS_PRIV]   = pstate_i[PS_PRIV];
                pstate_o[PS_PEF]    = 1'b1;
                hpstate_o[HS_RED]   = 1'b1;
                hpstate_o[HS_HPRIV] = 1'b1;
                hpstate_o[HS_IBE]   = 1'b0;
                hpstate_o[HS_TLZ]   = 1'b0;
            end
            MODE_HYP: begin
                pstate_o[PS_PEF]    = 1'b1;
                pstate_o[PS_AM]     = 1'b0;
                pstate_o[PS_IE]     = 1'b0;
                pstate_o[PS_CLE]    = 1'b0;
                hpstate_o[HS_RED]   = 1'b0;
                hpstate_o[HS_HPRIV] = 1'b1;
                hpstate_o[HS_IBE]   = 1'b0;
            end
            MODE_PRIV: begin
                pstate_o[PS_PEF]    = 1'b1;
                pstate_o[PS_AM]     = 1'b0;
                pstate_o[PS_IE]     = 1'b0;
                pstate_o[PS_PRIV]   = 1'b1;
                pstate_o[PS_CLE]    = pstate_i[PS_TLE];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_entry_pkg::*;
#(
    parameter int NWIN    = 8,
    parameter int MAX_TL  = 6,
    parameter int MAX_GL  = 3,
    parameter int MAX_PGL = 2,
    parameter int PC_W    = 48,
    localparam int TL_W   = $clog2(MAX_TL + 1),
    localparam int GL_W   = $clog2(MAX_GL + 1),
    localparam int CWP_W  = $clog2(NWIN)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trap_req,
    input  logic                to_hyp,
    input  logic                red_entry,
    input  logic [TL_W-1:0]     cur_tl,
    input  logic [GL_W-1:0]     cur_gl,
    input  logic [7:0]          cur_ccr,
    input  logic [7:0]          cur_asi,
    input  logic [12:0]         cur_pstate,
    input  logic [10:0]         cur_hpstate,
    input  logic [CWP_W-1:0]    cur_cwp,
    input  logic [CWP_W-1:0]    cur_cansave,
    input  logic [PC_W-1:0]     cur_pc,
    input  logic [PC_W-1:0]     cur_npc,
    input  logic [8:0]          trap_type,
    output logic                busy,
    output logic                stk_we,
    output logic [TL_W-1:0]     stk_idx,
    output logic [42:0]         stk_tstate,
    output logic [PC_W-1:0]     stk_tpc,
    output logic [PC_W-1:0]     stk_tnpc,
    output logic [10:0]         stk_htstate,
    output logic [8:0]          stk_tt,
    output logic                upd_valid,
    output logic [TL_W-1:0]     new_tl,
    output logic [GL_W-1:0]     new_gl,
    output logic [12:0]         new_pstate,
    output logic [10:0]         new_hpstate,
    output logic [CWP_W-1:0]    new_cwp
);
    tes_state_e state, state_nx;
    tes_mode_e  cap_mode;

    logic [TL_W-1:0]   cap_tl;
    logic [GL_W-1:0]   cap_gl;
    logic [CCR_W-1:0]  cap_ccr;
    logic [ASI_W-1:0]  cap_asi;
    logic [PST_W-1:0]  cap_pstate;
    logic [HPST_W-1:0] cap_hpstate;
    logic [CWP_W-1:0]  cap_cwp, cap_cansave;
    logic [PC_W-1:0]   cap_pc, cap_npc;
    logic [TT_W-1:0]   cap_tt;

    logic [TSTATE_W-1:0] packed_word;
    logic [GL_W-1:0]     xf_gl;
    logic [PST_W-1:0]    xf_pstate;
    logic [HPST_W-1:0]   xf_hpstate;
    logic [CWP_W-1:0]    rot_cwp;
    logic [TL_W:0]       tl_inc;
    logic [TL_W-1:0]     tl_next;

    trap_tstate_pack #(.GL_W(GL_W), .CWP_W(CWP_W)) u_pack (
        .gl_i(cap_gl), .ccr_i(cap_ccr), .asi_i(cap_asi),
        .pstate_i(cap_pstate), .cwp_i(cap_cwp), .word_o(packed_word)
    );

    trap_state_xform #(.GL_W(GL_W), .MAX_GL(MAX_GL), .MAX_PGL(MAX_PGL)) u_xform (
        .mode_i(cap_mode), .gl_i(cap_gl), .pstate_i(cap_pstate),
        .hpstate_i(cap_hpstate), .gl_o(xf_gl), .pstate_o(xf_pstate),
        .hpstate_o(xf_hpstate)
    );

    trap_cwp_rotate #(.NWIN(NWIN), .CWP_W(CWP_W)) u_rot (
        .tt_i(cap_tt), .cwp_i(cap_cwp), .cansave_i(cap_cansave), .cwp_o(rot_cwp)
    );

    always_comb begin
        tl_inc  = (TL_W+1)'(cap_tl) + (TL_W+1)'(1);
        tl_next = (tl_inc > (TL_W+1)'(MAX_TL)) ? TL_W'(MAX_TL) : TL_W'(tl_inc);
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (trap_req) state_nx = ST_SAVE;
            ST_SAVE:   state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register and input capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cap_mode    <= MODE_PRIV;
            cap_tl      <= '0;
            cap_gl      <= '0;
            cap_ccr     <= '0;
            cap_asi     <= '0;
            cap_pstate  <= '0;
            cap_hpstate <= '0;
            cap_cwp     <= '0;
            cap_cansave <= '0;
            cap_pc      <= '0;
            cap_npc     <= '0;
            cap_tt      <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && trap_req) begin
                cap_mode    <= red_entry ? MODE_RED : (to_hyp ? MODE_HYP : MODE_PRIV);
                cap_tl      <= cur_tl;
                cap_gl      <= cur_gl;
                cap_ccr     <= cur_ccr;
                cap_asi     <= cur_asi;
                cap_pstate  <= cur_pstate;
                cap_hpstate <= cur_hpstate;
                cap_cwp     <= cur_cwp;
                cap_cansave <= cur_cansave;
                cap_pc      <= cur_pc;
                cap_npc     <= cur_npc;
                cap_tt      <= trap_type;
            end
        end
    end

    // outputs
    always_comb begin
        busy        = (state != ST_IDLE);
        stk_we      = 1'b0;
        stk_idx     = '0;
        stk_tstate  = '0;
        stk_tpc     = '0;
        stk_tnpc    = '0;
        stk_htstate = '0;
        stk_tt      = '0;
        upd_valid   = 1'b0;
        new_tl      = '0;
        new_gl      = '0;
        new_pstate  = '0;
        new_hpstate = '0;
        new_cwp     = '0;
        unique case (state)
            ST_IDLE: ;
            ST_SAVE: begin
                stk_we      = 1'b1;
                stk_idx     = tl_next;
                stk_tstate  = packed_word;
                stk_tpc     = cap_pc;
                stk_tnpc    = cap_npc;
                stk_htstate = cap_hpstate;
                stk_tt      = cap_tt;
            end
            ST_COMMIT: begin
                upd_valid   = 1'b1;
                new_tl      = tl_next;
                new_gl      = xf_gl;
                new_pstate  = xf_pstate;
                new_hpstate = xf_hpstate;
                new_cwp     = rot_cwp;
            end
            default: ;
        endcase
    end

    // R1: accepted request writes in the next cycle, commit follows the write
    assert_write_after_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && trap_req) |=> stk_we);
    assert_commit_after_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stk_we |=> (upd_valid && !stk_we));
    // R3/R4: commit level matches the index written one cycle earlier
    assert_idx_matches_tl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (new_tl == $past(stk_idx) && new_tl != '0));
    // R5: global level never beyond its ceiling
    assert_gl_ceiling_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && cap_mode == MODE_PRIV) |-> (new_gl <= GL_W'(MAX_PGL)));
    // R7: hyperprivileged entry ends with hpriv set and red clear
    assert_hyp_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && cap_mode == MODE_HYP) |-> (new_hpstate[HS_HPRIV] && !new_hpstate[HS_RED]));
    // R9: RED entry ends with red set and tlz clear
    assert_red_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && cap_mode == MODE_RED) |-> (new_hpstate[HS_RED] && !new_hpstate[HS_TLZ]));
    // R12: no write while a sequence is in progress except the SAVE cycle
    assert_no_rewrite_R12: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> !stk_we);

endmodule

// File: tb/trap_entry_unit_tb.sv
module trap_entry_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NWIN = 8, MAX_TL = 6, MAX_GL = 3, MAX_PGL = 2, PC_W = 48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trap_req = 1'b0, to_hyp = 1'b0, red_entry = 1'b0;
    logic [2:0] cur_tl = '0;
    logic [1:0] cur_gl = '0;
    logic [7:0] cur_ccr = '0, cur_asi = '0;
    logic [12:0] cur_pstate = '0;
    logic [10:0] cur_hpstate = '0;
    logic [2:0] cur_cwp = '0, cur_cansave = '0;
    logic [PC_W-1:0] cur_pc = '0, cur_npc = '0;
    logic [8:0] trap_type = '0;

    logic busy, stk_we, upd_valid;
    logic [2:0] stk_idx, new_tl, new_cwp;
    logic [42:0] stk_tstate;
    logic [PC_W-1:0] stk_tpc, stk_tnpc;
    logic [10:0] stk_htstate, new_hpstate;
    logic [8:0] stk_tt;
    logic [1:0] new_gl;
    logic [12:0] new_pstate;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_entry_unit #(.NWIN(NWIN), .MAX_TL(MAX_TL), .MAX_GL(MAX_GL),
                      .MAX_PGL(MAX_PGL), .PC_W(PC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .to_hyp(to_hyp),
        .red_entry(red_entry), .cur_tl(cur_tl), .cur_gl(cur_gl),
        .cur_ccr(cur_ccr), .cur_asi(cur_asi), .cur_pstate(cur_pstate),
        .cur_hpstate(cur_hpstate), .cur_cwp(cur_cwp), .cur_cansave(cur_cansave),
        .cur_pc(cur_pc), .cur_npc(cur_npc), .trap_type(trap_type),
        .busy(busy), .stk_we(stk_we), .stk_idx(stk_idx), .stk_tstate(stk_tstate),
        .stk_tpc(stk_tpc), .stk_tnpc(stk_tnpc), .stk_htstate(stk_htstate),
        .stk_tt(stk_tt), .upd_valid(upd_valid), .new_tl(new_tl), .new_gl(new_gl),
        .new_pstate(new_pstate), .new_hpstate(new_hpstate), .new_cwp(new_cwp)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // expected values built from the requirement text
    function automatic logic [42:0] exp_tstate(input logic [1:0] gl, input logic [7:0] ccr,
        input logic [7:0] asi, input logic [12:0] ps, input logic [2:0] cwp);
        logic [42:0] w = '0;
        w[42:40] = {1'b0, gl}; w[39:32] = ccr; w[31:24] = asi;
        w[20:8] = ps; w[4:0] = {2'b00, cwp};
        return w;
    endfunction

    function automatic int exp_cwp(input int tt, input int cwp, input int cs);
        if (tt >= 'h80 && tt <= 'hBF) return (cwp + cs + 2) % NWIN;
        if (tt >= 'hC0 && tt <= 'hFF) return (cwp + NWIN - 1) % NWIN;
        if (tt == 'h24) return (cwp + 1) % NWIN;
        return cwp;
    endfunction

    // one full trap; mode: 0 priv, 1 hyp, 2 red
    task automatic run_trap(input string tag, input int mode, input int tl, input int gl,
        input logic [12:0] ps, input logic [10:0] hps, input int cwp, input int cs,
        input int tt, input logic [12:0] e_ps, input logic [10:0] e_hps, input int e_gl);
        int e_tl;
        e_tl = (tl + 1 > MAX_TL) ? MAX_TL : tl + 1;
        @(negedge clk);
        to_hyp = (mode == 1); red_entry = (mode == 2);
        cur_tl = 3'(tl); cur_gl = 2'(gl); cur_ccr = 8'hA5; cur_asi = 8'h3C;
        cur_pstate = ps; cur_hpstate = hps; cur_cwp = 3'(cwp); cur_cansave = 3'(cs);
        cur_pc = 48'h1234_5678_9AB0; cur_npc = 48'h1234_5678_9AB4; trap_type = 9'(tt);
        trap_req = 1'b1;
        @(negedge clk);
        trap_req = 1'b0;
        chk("R1", {tag, " stk_we"}, 64'(stk_we), 64'd1);
        chk("R1", {tag, " busy"}, 64'(busy), 64'd1);
        chk("R2", {tag, " tstate"}, 64'(stk_tstate),
            64'(exp_tstate(2'(gl), 8'hA5, 8'h3C, ps, 3'(cwp))));
        chk("R3", {tag, " idx"}, 64'(stk_idx), 64'(e_tl));
        chk("R3", {tag, " tpc"}, 64'(stk_tpc), 64'h1234_5678_9AB0);
        chk("R3", {tag, " tnpc"}, 64'(stk_tnpc), 64'h1234_5678_9AB4);
        chk("R3", {tag, " htstate"}, 64'(stk_htstate), 64'(hps));
        chk("R3", {tag, " tt"}, 64'(stk_tt), 64'(tt));
        @(negedge clk);
        chk("R1", {tag, " upd_valid"}, 64'(upd_valid), 64'd1);
        chk("R1", {tag, " we low in commit"}, 64'(stk_we), 64'd0);
        chk("R4", {tag, " new_tl"}, 64'(new_tl), 64'(e_tl));
        chk("R5", {tag, " new_gl"}, 64'(new_gl), 64'(e_gl));
        chk("R6", {tag, " new_pstate"}, 64'(new_pstate), 64'(e_ps));
        chk("R7", {tag, " new_hpstate"}, 64'(new_hpstate), 64'(e_hps));
        chk("R10", {tag, " new_cwp"}, 64'(new_cwp), 64'(exp_cwp(tt, cwp, cs)));
        @(negedge clk);
        chk("R1", {tag, " idle busy"}, 64'(busy), 64'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "reset stk_we", 64'(stk_we), 64'd0);
        chk("R1", "reset upd_valid", 64'(upd_valid), 64'd0);
        chk("R1", "reset busy", 64'(busy), 64'd0);
    endtask

    // R7 R6: hyper entry; ps 0x30A -> set pef, clear am ie cle -> 0x110
    task automatic t_hyper();
        run_trap("R7 hyp", 1, 1, 0, 13'h30A, 11'h421, 3, 2, 'h030, 13'h110, 11'h005, 1);
    endtask

    // R8: priv entry; ps 0x10A -> pef, priv, cle=tle, clear am ie -> 0x314
    task automatic t_priv();
        run_trap("R8 priv", 0, 0, 0, 13'h10A, 11'h421, 3, 2, 'h010, 13'h314, 11'h421, 1);
    endtask

    // R9: red entry overrides hyp flag (mode value 2), ps 0x3FF -> 0x014
    task automatic t_red();
        to_hyp = 1'b1;
        run_trap("R9 red", 2, 2, 3, 13'h3FF, 11'h403, 1, 0, 'h005, 13'h014, 11'h026, 3);
    endtask

    // R10: spill wraps: cwp 6 + cansave 5 + 2 = 13 mod 8 = 5
    task automatic t_spill();
        run_trap("R10 spill", 1, 0, 1, 13'h000, 11'h000, 6, 5, 'h0A4, 13'h010, 11'h004, 2);
    endtask

    // R11: fill at cwp 0 wraps to 7; clean at cwp 7 wraps to 0
    task automatic t_fill_clean();
        run_trap("R11 fill", 0, 1, 0, 13'h000, 11'h000, 0, 3, 'h0C8, 13'h014, 11'h000, 1);
        run_trap("R11 clean", 0, 1, 0, 13'h000, 11'h000, 7, 3, 'h024, 13'h014, 11'h000, 1);
    endtask

    // R4 R5: saturation of trap level and global level ceilings
    task automatic t_saturate();
        run_trap("R4 tl sat", 0, 6, 2, 13'h000, 11'h000, 2, 1, 'h011, 13'h014, 11'h000, 2);
        run_trap("R5 hyp gl sat", 1, 5, 3, 13'h000, 11'h000, 2, 1, 'h011, 13'h010, 11'h004, 3);
    endtask

    // R12: strobe during busy ignored
    task automatic t_busy_ignore();
        @(negedge clk);
        to_hyp = 1'b0; red_entry = 1'b0;
        cur_tl = 3'd0; cur_gl = 2'd0; cur_pstate = 13'h000; cur_hpstate = 11'h000;
        cur_cwp = 3'd2; cur_cansave = 3'd0; trap_type = 9'h010;
        trap_req = 1'b1;
        @(negedge clk);
        cur_tl = 3'd3; trap_type = 9'h0C0; to_hyp = 1'b1;   // second strobe, kept high
        @(negedge clk);
        chk("R12", "commit from first trap tl", 64'(new_tl), 64'd1);
        chk("R12", "commit from first trap cwp", 64'(new_cwp), 64'd2);
        chk("R12", "commit from first trap gl", 64'(new_gl), 64'd1);
        trap_req = 1'b0;
        @(negedge clk);
        chk("R12", "no second write", 64'(stk_we), 64'd0);
        chk("R12", "idle after ignore", 64'(busy), 64'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_hyper();
        t_priv();
        t_red();
        t_spill();
        t_fill_clean();
        t_saturate();
        t_busy_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule